// File: doc/BRIEF.md
# Combined GPR/SPR Register File with Bypass and Debug Peek

This block is the architectural register store of a small in-order processor core. One array of 64 entries, 64 bits each, holds both the general-purpose registers (entries 0 to 31) and the frequently accessed special registers such as the loop count and return link (entries 32 to 63). The decode stage reads up to three source operands per cycle through ports A, B and C. The writeback stage updates one entry per cycle through a single write port. A write is bypassed combinationally to any port that reads the same entry in the same cycle, so no separate forwarding network is needed downstream.

A debug agent can inspect any entry, or the machine status word that arrives on an input, without stalling the pipeline. An entry inspection borrows port B, but only in a cycle where decode has not raised the port B read enable. While decode keeps port B busy, the request waits. Small package functions convert a 5-bit general-purpose index into the 6-bit combined index space, and the reverse.

Top module: `gspr_regfile`

## Requirements
- R1: A write with `wr_en` high updates entry `wr_idx` at the rising clock edge, and every later read of that entry returns the written value until it is overwritten.
- R2: Ports A, B and C each return, combinationally and independently, the entry named by their own index while their read enable is high.
- R3: When `wr_en` is high and a port's index equals `wr_idx`, that port returns `wr_data` in the same cycle.
- R4: With `wr_en` low, the values on `wr_idx` and `wr_data` leave every entry unchanged.
- R5: A pending entry inspection (`dbg_req` high, `dbg_sel_status` low) receives no `dbg_ack` in any cycle that follows one in which `rd_en_b` was high. Port B keeps serving decode during that time.
- R6: An entry inspection is served in the first cycle where `rd_en_b` is low. `dbg_ack` rises in the next cycle, with `dbg_data` holding the entry's value.
- R7: `dbg_ack` is high for exactly one cycle per served request and is never high on two consecutive cycles.
- R8: A status inspection (`dbg_sel_status` high) is served regardless of `rd_en_b`. `dbg_ack` rises in the next cycle, with `dbg_data` equal to `status_in` as sampled on the serving edge.
- R9: While `rst` is high and after its release, `dbg_ack` and `dbg_data` are 0 until the first request is served.
- R10: General-purpose index g (0..31) maps to combined index g with bit 5 clear. Combined indices with bit 5 set are special registers held in storage that is separate from the general-purpose registers. For example, entries 5 and 37 hold independent values.
- R11: An entry inspection served in the same cycle as a write to the same entry returns the value being written.
- R12: A port whose read enable is low drives 0 on its data output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the debug path |
| rd_en_a | input | 1 | Decode uses port A |
| rd_idx_a | input | 6 | Port A entry index |
| rd_data_a | output | 64 | Port A read data |
| rd_en_b | input | 1 | Decode uses port B; low frees port B for debug |
| rd_idx_b | input | 6 | Port B entry index |
| rd_data_b | output | 64 | Port B read data |
| rd_en_c | input | 1 | Decode uses port C |
| rd_idx_c | input | 6 | Port C entry index |
| rd_data_c | output | 64 | Port C read data |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 6 | Write entry index |
| wr_data | input | 64 | Write data |
| status_in | input | 64 | Machine status word to be inspected |
| dbg_req | input | 1 | Debug request, held until acknowledged |
| dbg_sel_status | input | 1 | 1: inspect status word, 0: inspect entry |
| dbg_idx | input | 6 | Entry to inspect |
| dbg_ack | output | 1 | One-cycle acknowledge, data valid |
| dbg_data | output | 64 | Inspected value |

## Verification
The hardest situation to reach is a debug inspection that is held off by decode traffic. It then lands on the very edge where writeback updates the same entry. The bench holds `rd_en_b` high for several cycles with a request pending and confirms that no acknowledge appears. It then drops `rd_en_b` in exactly the cycle it raises `wr_en` on the requested index. The scoreboard expects the new value one cycle later. Status inspections are issued with port B deliberately busy, to show that they bypass that arbitration.

// File: rtl/gspr_rf_pkg.sv
package gspr_rf_pkg;

    localparam int GPR_IDX_W  = 5;
    localparam int COMB_IDX_W = GPR_IDX_W + 1;
    localparam int WORD_W     = 64;
    localparam int RD_PORTS   = 3;

    typedef logic [GPR_IDX_W-1:0]  gpr_idx_t;
    typedef logic [COMB_IDX_W-1:0] comb_idx_t;
    typedef logic [WORD_W-1:0]     word_t;

    // Source of the value returned on the debug data output
    typedef enum logic {
        DBG_SRC_ENTRY  = 1'b0,
        DBG_SRC_STATUS = 1'b1
    } dbg_src_e;

    typedef struct packed {
        logic      en;
        comb_idx_t idx;
        word_t     data;
    } wr_req_t;

    // General-purpose index -> combined index (special bit cleared)
    function automatic comb_idx_t gpr_to_comb(input gpr_idx_t g);
        return {1'b0, g};
    endfunction

    // Special-register slot -> combined index (special bit set)
    function automatic comb_idx_t spr_to_comb(input gpr_idx_t s);
        return {1'b1, s};
    endfunction

    function automatic logic comb_is_special(input comb_idx_t c);
        return c[COMB_IDX_W-1];
    endfunction

    function automatic gpr_idx_t comb_to_gpr(input comb_idx_t c);
        return c[GPR_IDX_W-1:0];
    endfunction

endpackage

// File: rtl/gspr_rf_array.sv
module gspr_rf_array #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 6,
    parameter int NUM_RD = 3
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [NUM_RD*IDX_W-1:0]  rd_idx_flat,
    output logic [NUM_RD*DATA_W-1:0] rd_data_flat
);
    localparam int DEPTH = 1 << IDX_W;

    // Plain storage, no reset, asynchronous read: maps onto LUT RAM
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        assign rd_data_flat[p*DATA_W +: DATA_W] = mem[rd_idx_flat[p*IDX_W +: IDX_W]];
    end

endmodule

// File: rtl/gspr_rf_bypass.sv
module gspr_rf_bypass #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 6
) (
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] stored,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] fwd_data
);
    always_comb begin
        if (wr_en && (wr_idx == rd_idx)) begin
            fwd_data = wr_data;
        end else begin
            fwd_data = stored;
        end
    end
endmodule

// File: rtl/gspr_rf_dbg.sv
module gspr_rf_dbg
    import gspr_rf_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              sel_status,
    input  logic              portb_busy,
    input  logic [DATA_W-1:0] portb_data,
    input  logic [DATA_W-1:0] status_in,
    output logic              steal_b,
    output logic              ack,
    output logic [DATA_W-1:0] data
);
    dbg_src_e src;
    logic     serve;

    assign src     = sel_status ? DBG_SRC_STATUS : DBG_SRC_ENTRY;
    assign steal_b = req && !ack && (src == DBG_SRC_ENTRY) && !portb_busy;
    assign serve   = req && !ack && ((src == DBG_SRC_STATUS) || !portb_busy);

    always_ff @(posedge clk) begin
        if (rst) begin
            ack  <= 1'b0;
            data <= '0;
        end else begin
            ack <= serve;
            if (serve) begin
                data <= (src == DBG_SRC_STATUS) ? status_in : portb_data;
            end
        end
    end
endmodule

// File: rtl/gspr_regfile.sv
module gspr_regfile
    import gspr_rf_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int IDX_W  = COMB_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en_a,
    input  logic [IDX_W-1:0]  rd_idx_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic              rd_en_b,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              rd_en_c,
    input  logic [IDX_W-1:0]  rd_idx_c,
    output logic [DATA_W-1:0] rd_data_c,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] status_in,
    input  logic              dbg_req,
    input  logic              dbg_sel_status,
    input  logic [IDX_W-1:0]  dbg_idx,
    output logic              dbg_ack,
    output logic [DATA_W-1:0] dbg_data
);
    localparam int NP = RD_PORTS;

    logic                    steal_b;
    logic [IDX_W-1:0]        idx_b_eff;
    logic [NP*IDX_W-1:0]     idx_flat;
    logic [NP*DATA_W-1:0]    raw_flat;
    logic [DATA_W-1:0]       fwd     [NP];
    logic [IDX_W-1:0]        idx_arr [NP];
    logic [NP-1:0]           en_vec;

    // Port B index is handed to debug only when decode leaves it idle
    assign idx_b_eff  = steal_b ? dbg_idx : rd_idx_b;
    assign idx_arr[0] = rd_idx_a;
    assign idx_arr[1] = idx_b_eff;
    assign idx_arr[2] = rd_idx_c;
    assign en_vec     = {rd_en_c, rd_en_b, rd_en_a};

    for (genvar p = 0; p < NP; p++) begin : g_port
        assign idx_flat[p*IDX_W +: IDX_W] = idx_arr[p];

        gspr_rf_bypass #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_byp (
            .rd_idx   (idx_arr[p]),
            .stored   (raw_flat[p*DATA_W +: DATA_W]),
            .wr_en    (wr_en),
            .wr_idx   (wr_idx),
            .wr_data  (wr_data),
            .fwd_data (fwd[p])
        );
    end

    gspr_rf_array #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_RD(NP)) u_array (
        .clk          (clk),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_data      (wr_data),
        .rd_idx_flat  (idx_flat),
        .rd_data_flat (raw_flat)
    );

    gspr_rf_dbg #(.DATA_W(DATA_W)) u_dbg (
        .clk        (clk),
        .rst        (rst),
        .req        (dbg_req),
        .sel_status (dbg_sel_status),
        .portb_busy (rd_en_b),
        .portb_data (fwd[1]),
        .status_in  (status_in),
        .steal_b    (steal_b),
        .ack        (dbg_ack),
        .data       (dbg_data)
    );

    // Quiet outputs on ports decode is not using
    assign rd_data_a = en_vec[0] ? fwd[0] : '0;
    assign rd_data_b = en_vec[1] ? fwd[1] : '0;
    assign rd_data_c = en_vec[2] ? fwd[2] : '0;

endmodule

// File: rtl/gspr_rf_chk.sv
module gspr_rf_chk #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en_a,
    input logic [IDX_W-1:0]  rd_idx_a,
    input logic [DATA_W-1:0] rd_data_a,
    input logic              rd_en_b,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] status_in,
    input logic              dbg_req,
    input logic              dbg_sel_status,
    input logic              dbg_ack,
    input logic [DATA_W-1:0] dbg_data
);
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        dbg_ack |=> !dbg_ack); // R7

    AST_WAIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!dbg_sel_status && rd_en_b) |=> !dbg_ack); // R5

    AST_SERVE_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        (dbg_req && !dbg_ack && !dbg_sel_status && !rd_en_b) |=> dbg_ack); // R6

    AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (rst)
        !dbg_req |=> !dbg_ack); // R6

    AST_STATUS_VALUE: assert property (@(posedge clk) disable iff (rst)
        (dbg_req && !dbg_ack && dbg_sel_status) |=> (dbg_ack && dbg_data == $past(status_in))); // R8

    AST_FWD_PORT_A: assert property (@(posedge clk) disable iff (rst)
        (rd_en_a && wr_en && rd_idx_a == wr_idx) |-> (rd_data_a == wr_data)); // R3

    AST_QUIET_PORT_A: assert property (@(posedge clk) disable iff (rst)
        !rd_en_a |-> (rd_data_a == '0)); // R12
endmodule

bind gspr_regfile gspr_rf_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .rd_en_a        (rd_en_a),
    .rd_idx_a       (rd_idx_a),
    .rd_data_a      (rd_data_a),
    .rd_en_b        (rd_en_b),
    .wr_en          (wr_en),
    .wr_idx         (wr_idx),
    .wr_data        (wr_data),
    .status_in      (status_in),
    .dbg_req        (dbg_req),
    .dbg_sel_status (dbg_sel_status),
    .dbg_ack        (dbg_ack),
    .dbg_data       (dbg_data)
);

// File: tb/gspr_regfile_test.sv
`timescale 1ns/1ps
module gspr_regfile_test;
    import gspr_rf_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en_a = 0, rd_en_b = 0, rd_en_c = 0;
    logic [5:0]  rd_idx_a = 0, rd_idx_b = 0, rd_idx_c = 0;
    logic [63:0] rd_data_a, rd_data_b, rd_data_c;
    logic        wr_en = 0;
    logic [5:0]  wr_idx = 0;
    logic [63:0] wr_data = 0;
    logic [63:0] status_in = 0;
    logic        dbg_req = 0, dbg_sel_status = 0;
    logic [5:0]  dbg_idx = 0;
    logic        dbg_ack;
    logic [63:0] dbg_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [63:0] model [64];
    logic [63:0] exp_q [$];

    always #2 clk = ~clk;

    gspr_regfile uut (.*);

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Scoreboard monitor: every acknowledge must match the oldest expectation
    always @(negedge clk) begin
        if (!rst && dbg_ack) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R7: got unexpected ack expected none");
            end else begin
                check("R6/R8/R11 debug data", dbg_data, exp_q.pop_front());
            end
        end
    end

    task automatic do_write(input logic [5:0] idx, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        model[idx] = d;
    endtask

    task automatic read3(input logic [5:0] a, input logic [5:0] b, input logic [5:0] c);
        @(negedge clk);
        rd_en_a = 1; rd_en_b = 1; rd_en_c = 1;
        rd_idx_a = a; rd_idx_b = b; rd_idx_c = c;
        #1;
        check("R2 port A", rd_data_a, model[a]);
        check("R2 port B", rd_data_b, model[b]);
        check("R2 port C", rd_data_c, model[c]);
        rd_en_a = 0; rd_en_b = 0; rd_en_c = 0;
    endtask

    // Wait for the acknowledge; returns the number of negedges waited
    task automatic wait_ack(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!dbg_ack && n < 50);
        dbg_req = 0;
        @(negedge clk);
        check("R7 ack drops", {63'b0, dbg_ack}, 64'd0);
    endtask

    task automatic dbg_entry(input logic [5:0] idx, input int busy);
        int n;
        @(negedge clk);
        dbg_req = 1; dbg_sel_status = 0; dbg_idx = idx;
        rd_en_b = (busy > 0); rd_idx_b = 6'd2;
        exp_q.push_back(model[idx]);
        for (int i = 0; i < busy; i++) begin
            @(negedge clk);
            check("R5 no ack while port B busy", {63'b0, dbg_ack}, 64'd0);
            check("R5 port B still serves decode", rd_data_b, model[2]);
        end
        rd_en_b = 0;
        wait_ack(n);
        check("R6 ack latency", n, 1);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R9 ack in reset", {63'b0, dbg_ack}, 64'd0);
        check("R9 data in reset", dbg_data, 64'd0);
        rst = 0;
        @(negedge clk);
        check("R9 ack after reset", {63'b0, dbg_ack}, 64'd0);

        for (int i = 0; i < 64; i++) do_write(i[5:0], {32'hA5A5_0000 | i, 32'h1234_5678 ^ (i * 32'h0101_0101)});
        read3(6'd1, 6'd2, 6'd3);
        read3(6'd63, 6'd32, 6'd0);
        do_write(6'd7, 64'hDEAD_BEEF_0000_0007);
        read3(6'd7, 6'd7, 6'd8);                      // R1

        // R3: same-cycle write bypass on all ports
        @(negedge clk);
        wr_en = 1; wr_idx = 6'd9; wr_data = 64'hFEED_FACE_CAFE_0009;
        rd_en_a = 1; rd_en_b = 1; rd_en_c = 1;
        rd_idx_a = 6'd9; rd_idx_b = 6'd9; rd_idx_c = 6'd9;
        #1;
        check("R3 port A", rd_data_a, 64'hFEED_FACE_CAFE_0009);
        check("R3 port B", rd_data_b, 64'hFEED_FACE_CAFE_0009);
        check("R3 port C", rd_data_c, 64'hFEED_FACE_CAFE_0009);
        @(negedge clk);
        wr_en = 0; rd_en_a = 0; rd_en_b = 0; rd_en_c = 0;
        model[9] = 64'hFEED_FACE_CAFE_0009;
        read3(6'd9, 6'd10, 6'd9);

        // R4: write data ignored without strobe
        @(negedge clk);
        wr_en = 0; wr_idx = 6'd11; wr_data = 64'h0BAD_0BAD_0BAD_0BAD;
        @(negedge clk);
        read3(6'd11, 6'd11, 6'd11);

        // R10: GPR 5 and special slot 5 are distinct
        do_write(gpr_to_comb(5'd5), 64'h1111_1111_1111_1111);
        do_write(spr_to_comb(5'd5), 64'h2222_2222_2222_2222);
        check("R10 special bit", {63'b0, comb_is_special(spr_to_comb(5'd5))}, 64'd1);
        check("R10 gpr maps low", {58'b0, gpr_to_comb(5'd5)}, 64'd5);
        read3(6'd5, 6'd37, 6'd5);

        // R12: disabled port reads zero
        @(negedge clk);
        rd_en_a = 0; rd_idx_a = 6'd5; rd_en_c = 1; rd_idx_c = 6'd5;
        #1;
        check("R12 quiet port A", rd_data_a, 64'd0);
        check("R12 enabled port C", rd_data_c, model[5]);
        rd_en_c = 0;

        // R5/R6: debug entry reads with and without contention
        dbg_entry(6'd37, 0);
        dbg_entry(6'd20, 4);
        dbg_entry(6'd0, 1);

        // R11: debug served on the same edge as a write to that entry
        @(negedge clk);
        dbg_req = 1; dbg_sel_status = 0; dbg_idx = 6'd40; rd_en_b = 1;
        @(negedge clk);
        check("R5 waiting", {63'b0, dbg_ack}, 64'd0);
        rd_en_b = 0;
        wr_en = 1; wr_idx = 6'd40; wr_data = 64'h0123_4567_89AB_CDEF;
        exp_q.push_back(64'h0123_4567_89AB_CDEF);
        model[40] = 64'h0123_4567_89AB_CDEF;
        wait_ack(n);
        wr_en = 0;
        check("R11 ack latency", n, 1);
        read3(6'd40, 6'd40, 6'd40);

        // R8: status read is not blocked by port B use
        @(negedge clk);
        dbg_req = 1; dbg_sel_status = 1; rd_en_b = 1; status_in = 64'h8000_0000_0000_1033;
        exp_q.push_back(64'h8000_0000_0000_1033);
        wait_ack(n);
        check("R8 status latency", n, 1);
        rd_en_b = 0; dbg_sel_status = 0;

        repeat (3) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule